// File: doc/BRIEF.md
# Event Time-Stamp Log with Overflow Tracking

This block records the time at which events occur into a small on-chip log while a recording session is active. Each accepted event writes the current time value into the location named by a write pointer, which then advances. Alongside the log, the block keeps a saturating count of every accepted event and holds the time of the first event of the session as a start stamp.

Once every location has been written, later events are handled in one of two ways, chosen by a mode input. With wrapping enabled they overwrite the oldest entries in turn. With wrapping disabled they are dropped. In both cases a sticky overflow flag is raised and the event count keeps rising. A clear request empties the whole log one address per clock and zeroes the count, the start stamp and the flag. A one-cycle done pulse marks the end of the sweep. Stored entries can be read at any time through a combinational read port.

Top module: `evlog_rollover`

## Requirements
- R1: After reset `wr_ptr`, `evt_count`, `start_stamp`, `roll_flag` and `clear_done` are all zero.
- R2: An accepted event is one where `evt_strobe` and `mission_on` are high in a cycle with no sweep running and no `clear_req`. While the log is not full, an accepted event stores `time_now` at `wr_ptr`. `wr_ptr` then advances by one, and after location DEPTH-1 it returns to 0 and the log becomes full.
- R3: With `mission_on` low, `evt_strobe` changes neither the log, the count, the pointer nor the flag.
- R4: The first accepted event after `mission_on` was low, after a clear, or after reset loads `time_now` into `start_stamp`. Later events in the same session leave it unchanged.
- R5: With `wrap_en` high and the log full, an accepted event overwrites the entry at `wr_ptr`, advances the pointer modulo DEPTH and sets `roll_flag`.
- R6: With `wrap_en` low and the log full, an accepted event is not stored and `wr_ptr` holds, but `roll_flag` is set.
- R7: `evt_count` rises by one on every accepted event, full or not, and stays at 2^CNT_W-1 once it gets there.
- R8: A `clear_req` seen with no sweep running zeroes `evt_count`, `start_stamp`, `roll_flag` and `wr_ptr` at that edge. It then writes zero to addresses 0 to DEPTH-1, one per clock in rising order. `clear_done` is high for exactly one cycle after the DEPTH-th sweep edge.
- R9: During a sweep, events and further clear requests are ignored.
- R10: `roll_flag` is cleared only by an accepted clear request.
- R11: `rd_data` shows the entry stored at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_strobe | input | 1 | Event occurred this cycle |
| time_now | input | TS_W | Current time value |
| mission_on | input | 1 | Recording session active |
| wrap_en | input | 1 | 1: overwrite when full, 0: drop when full |
| clear_req | input | 1 | Request to empty the log |
| rd_addr | input | AW | Read address |
| rd_data | output | TS_W | Entry at `rd_addr` |
| wr_ptr | output | AW | Next location to be written |
| evt_count | output | CNT_W | Saturating count of accepted events |
| start_stamp | output | TS_W | Time of the first event of the session |
| roll_flag | output | 1 | Sticky overflow flag |
| clear_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the block with DEPTH=4, CNT_W=4 and TS_W=16. A four-entry log fills after a handful of events, so both full-log policies and several wraps of the pointer happen within a short run. A four-bit counter reaches its ceiling of 15 inside the same run, which exercises saturation. The short sweep also lets events and a second clear request be placed in every sweep cycle, and the read address steps through all locations to check each stored entry.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
   typedef enum logic [0:0] {
      PH_RUN   = 1'b0,
      PH_SWEEP = 1'b1
   } evlog_phase_e;
endpackage

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
   import evlog_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_strobe,
   input  logic          mission_on,
   input  logic          wrap_en,
   input  logic          clear_req,
   output logic [AW-1:0] wr_ptr,
   output logic          log_full,
   output logic          roll_flag,
   output logic          sweeping,
   output logic [AW-1:0] sweep_addr,
   output logic          clear_done,
   output logic          clear_go,
   output logic          take_evt,
   output logic          store_we,
   output logic          load_start
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   evlog_phase_e phase_q;
   logic         arm_q;

   assign sweeping   = (phase_q == PH_SWEEP);
   assign clear_go   = clear_req && !sweeping;
   assign take_evt   = evt_strobe && mission_on && !sweeping && !clear_req;
   assign store_we   = take_evt && (!log_full || wrap_en);
   assign load_start = take_evt && arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_RUN;
         sweep_addr <= '0;
         clear_done <= 1'b0;
      end else begin
         clear_done <= 1'b0;
         if (sweeping) begin
            if (sweep_addr == LAST) begin
               phase_q    <= PH_RUN;
               clear_done <= 1'b1;
            end else begin
               sweep_addr <= sweep_addr + 1'b1;
            end
         end else if (clear_go) begin
            phase_q    <= PH_SWEEP;
            sweep_addr <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         log_full  <= 1'b0;
         roll_flag <= 1'b0;
      end else if (clear_go) begin
         wr_ptr    <= '0;
         log_full  <= 1'b0;
         roll_flag <= 1'b0;
      end else begin
         if (take_evt && log_full) roll_flag <= 1'b1;
         if (store_we) begin
            if (wr_ptr == LAST) begin
               wr_ptr   <= '0;
               log_full <= 1'b1;
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  arm_q <= 1'b1;
      else if (clear_go)           arm_q <= 1'b1;
      else if (!mission_on)        arm_q <= 1'b1;
      else if (take_evt)           arm_q <= 1'b0;
   end
endmodule

// File: rtl/evlog_counter.sv
module evlog_counter #(
   parameter int CNT_W = 16,
   parameter int TS_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_go,
   input  logic             take_evt,
   input  logic             load_start,
   input  logic [TS_W-1:0]  time_now,
   output logic [CNT_W-1:0] evt_count,
   output logic [TS_W-1:0]  start_stamp
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               evt_count <= '0;
      else if (clear_go)                        evt_count <= '0;
      else if (take_evt && evt_count != CNT_TOP) evt_count <= evt_count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          start_stamp <= '0;
      else if (clear_go)   start_stamp <= '0;
      else if (load_start) start_stamp <= time_now;
   end
endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
   parameter int DEPTH = 16,
   parameter int TS_W  = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [TS_W-1:0] wdata,
   input  logic [AW-1:0]   rd_addr,
   output logic [TS_W-1:0] rd_data
);
   logic [TS_W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (we && waddr == AW'(i)) ent[i] <= wdata;
      end
   end

   if (DEPTH == (1 << AW)) begin : g_full_range
      assign rd_data = ent[rd_addr];
   end else begin : g_guarded
      always_comb begin
         rd_data = '0;
         for (int k = 0; k < DEPTH; k++) begin
            if (rd_addr == AW'(k)) rd_data = ent[k];
         end
      end
   end
endmodule

// File: rtl/evlog_rollover.sv
module evlog_rollover #(
   parameter int DEPTH = 16,
   parameter int TS_W  = 32,
   parameter int CNT_W = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_strobe,
   input  logic [TS_W-1:0]  time_now,
   input  logic             mission_on,
   input  logic             wrap_en,
   input  logic             clear_req,
   input  logic [AW-1:0]    rd_addr,
   output logic [TS_W-1:0]  rd_data,
   output logic [AW-1:0]    wr_ptr,
   output logic [CNT_W-1:0] evt_count,
   output logic [TS_W-1:0]  start_stamp,
   output logic             roll_flag,
   output logic             clear_done
);
   if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (TS_W < 1)   begin : g_bad_ts    $error("TS_W must be at least 1"); end
   if (CNT_W < 1)  begin : g_bad_cnt   $error("CNT_W must be at least 1"); end

   logic          log_full, sweeping, clear_go, take_evt, store_we, load_start;
   logic [AW-1:0] sweep_addr;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [TS_W-1:0] mem_data;

   evlog_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_strobe (evt_strobe),
      .mission_on (mission_on),
      .wrap_en    (wrap_en),
      .clear_req  (clear_req),
      .wr_ptr     (wr_ptr),
      .log_full   (log_full),
      .roll_flag  (roll_flag),
      .sweeping   (sweeping),
      .sweep_addr (sweep_addr),
      .clear_done (clear_done),
      .clear_go   (clear_go),
      .take_evt   (take_evt),
      .store_we   (store_we),
      .load_start (load_start)
   );

   evlog_counter #(.CNT_W(CNT_W), .TS_W(TS_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_go    (clear_go),
      .take_evt    (take_evt),
      .load_start  (load_start),
      .time_now    (time_now),
      .evt_count   (evt_count),
      .start_stamp (start_stamp)
   );

   assign mem_we   = sweeping || store_we;
   assign mem_addr = sweeping ? sweep_addr : wr_ptr;
   assign mem_data = sweeping ? '0 : time_now;

   evlog_store #(.DEPTH(DEPTH), .TS_W(TS_W), .AW(AW)) u_store (
      .clk     (clk),
      .we      (mem_we),
      .waddr   (mem_addr),
      .wdata   (mem_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/evlog_rollover_chk.sv
module evlog_rollover_chk #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_strobe,
   input logic             mission_on,
   input logic             wrap_en,
   input logic             clear_req,
   input logic [AW-1:0]    wr_ptr,
   input logic [CNT_W-1:0] evt_count,
   input logic             roll_flag,
   input logic             clear_done,
   input logic             sweeping,
   input logic             log_full
);
   logic accepted, clr_ok;
   assign accepted = evt_strobe && mission_on && !sweeping && !clear_req;
   assign clr_ok   = clear_req && !sweeping;

   // R2 / R5: a stored event moves the pointer by one, modulo DEPTH
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && (!log_full || wrap_en)) |=>
      (wr_ptr == (($past(wr_ptr) == AW'(DEPTH - 1)) ? '0 : AW'($past(wr_ptr) + 1'b1))));

   // R6: a dropped event leaves the pointer in place and raises the flag
   a_r6_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && log_full && !wrap_en) |=> ($stable(wr_ptr) && roll_flag));

   // R3: no session, no count change
   a_r3_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!mission_on && !clr_ok) |=> $stable(evt_count));

   // R7: count never decreases except through a clear
   a_r7_count_mono: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_ok |=> (evt_count >= $past(evt_count)));

   // R8: done lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      clear_done |=> !clear_done);

   // R9: nothing is counted or stored during the sweep
   a_r9_sweep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sweeping |=> (evt_count == '0 && wr_ptr == '0));

   // R10: the flag is sticky until a clear
   a_r10_roll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (roll_flag && !clr_ok) |=> roll_flag);
endmodule

bind evlog_rollover evlog_rollover_chk #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_strobe (evt_strobe),
   .mission_on (mission_on),
   .wrap_en    (wrap_en),
   .clear_req  (clear_req),
   .wr_ptr     (wr_ptr),
   .evt_count  (evt_count),
   .roll_flag  (roll_flag),
   .clear_done (clear_done),
   .sweeping   (sweeping),
   .log_full   (log_full)
);

// File: tb/evlog_rollover_test.sv
`timescale 1ns/1ps
module evlog_rollover_test;
   localparam int DEPTH = 4;
   localparam int TS_W  = 16;
   localparam int CNT_W = 4;
   localparam int AW    = $clog2(DEPTH);
   localparam int CTOP  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_strobe = 1'b0, mission_on = 1'b0, wrap_en = 1'b0, clear_req = 1'b0;
   logic [TS_W-1:0] time_now = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [TS_W-1:0] rd_data, start_stamp;
   logic [AW-1:0]   wr_ptr;
   logic [CNT_W-1:0] evt_count;
   logic roll_flag, clear_done;

   always #2.5 clk = ~clk;

   evlog_rollover #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .time_now(time_now),
      .mission_on(mission_on), .wrap_en(wrap_en), .clear_req(clear_req),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr), .evt_count(evt_count),
      .start_stamp(start_stamp), .roll_flag(roll_flag), .clear_done(clear_done)
   );

   // behavioural reference
   int m_ptr, m_cnt, m_start, m_addr;
   bit m_full, m_roll, m_done, m_clr, m_arm, m_known;
   int mm [DEPTH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ptr = 0; m_cnt = 0; m_start = 0; m_addr = 0;
         m_full = 0; m_roll = 0; m_done = 0; m_clr = 0; m_arm = 1; m_known = 0;
      end else begin
         m_done = 0;
         if (m_clr) begin
            mm[m_addr] = 0;
            if (m_addr == DEPTH - 1) begin m_clr = 0; m_done = 1; m_known = 1; end
            else m_addr++;
         end else if (clear_req) begin
            m_clr = 1; m_addr = 0; m_cnt = 0; m_start = 0; m_ptr = 0;
            m_full = 0; m_roll = 0; m_arm = 1;
         end else if (evt_strobe && mission_on) begin
            if (m_arm) begin m_start = int'(time_now); m_arm = 0; end
            if (m_cnt < CTOP) m_cnt++;
            if (m_full) begin
               m_roll = 1;
               if (wrap_en) begin mm[m_ptr] = int'(time_now); m_ptr = (m_ptr + 1) % DEPTH; end
            end else begin
               mm[m_ptr] = int'(time_now);
               if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_full = 1; end
               else m_ptr++;
            end
         end
         if (!mission_on) m_arm = 1;
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check("R2", "wr_ptr", int'(wr_ptr), m_ptr);
      check("R7", "evt_count", int'(evt_count), m_cnt);
      check("R4", "start_stamp", int'(start_stamp), m_start);
      check("R10", "roll_flag", int'(roll_flag), int'(m_roll));
      check("R8", "clear_done", int'(clear_done), int'(m_done));
      if (m_known) check("R11", "rd_data", int'(rd_data), mm[int'(rd_addr)]);
   endtask

   int tcount = 100;
   task automatic step(input bit e, input bit m, input bit w, input bit c);
      @(negedge clk);
      compare_all();
      evt_strobe = e; mission_on = m; wrap_en = w; clear_req = c;
      tcount = tcount + 3;
      time_now = TS_W'(tcount);
      rd_addr = AW'(rd_addr + 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", "wr_ptr", int'(wr_ptr), 0);
      check("R1", "evt_count", int'(evt_count), 0);
      check("R1", "start_stamp", int'(start_stamp), 0);
      check("R1", "roll_flag", int'(roll_flag), 0);
      check("R1", "clear_done", int'(clear_done), 0);
      // R8: initial sweep
      step(0, 0, 0, 1);
      repeat (DEPTH + 2) step(0, 0, 0, 0);
      // R3: events without a session
      repeat (3) step(1, 0, 0, 0);
      // R2 / R4: session with gaps
      step(1, 1, 0, 0); step(0, 1, 0, 0); step(1, 1, 0, 0); step(1, 1, 0, 0);
      step(0, 1, 0, 0); step(1, 1, 0, 0);
      // R6: full, wrap off, events dropped
      repeat (3) step(1, 1, 0, 0);
      repeat (DEPTH) step(0, 1, 0, 0);
      // R4: new session re-arms start stamp
      step(0, 0, 0, 0); step(1, 1, 0, 0);
      // R5: wrap on, overwrite oldest; R7: count reaches ceiling
      repeat (10) step(1, 1, 1, 0);
      repeat (DEPTH) step(0, 1, 1, 0);
      // R9: clear while events and repeated clear requests arrive
      step(1, 1, 1, 1);
      repeat (DEPTH) step(1, 1, 1, 1);
      repeat (2) step(1, 1, 1, 0);
      step(0, 1, 0, 0);
      // R2 / R6 after clear, wrap off
      repeat (DEPTH + 2) step(1, 1, 0, 0);
      // R10: flag stays through idle and session toggles
      repeat (3) step(0, 0, 1, 0);
      step(1, 0, 1, 0);
      step(0, 1, 1, 0);
      // clear with no sweep overlap, then read back
      step(0, 0, 0, 1);
      repeat (DEPTH + 3) step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule